// File: doc/BRIEF.md
# Flyback Switching Cycle Timer

This block generates the gate-enable pulse train for a primary-side regulated flyback converter. It runs from a fast system clock, and every duration is counted in ticks of that clock. Each switching cycle begins with a turn-on. The on-time is ended by the first of two pulse-termination requests, one from the voltage regulation loop and one from the current loop. The on-time is also bounded by a minimum length, a blanking window for the current request and a maximum duty fraction.

The cycle period is a base count from an input port plus a slowly hopping offset. The offset spreads the switching spectrum in a triangular pattern around the base. The next turn-on also waits for the transformer to demagnetise. If the zero-crossing flag arrives late, turn-on follows it after a tenth of the period. If the flag never arrives, a long cycle limit forces the next start.

A halt input, driven by protection or burst logic, drops the gate in the same clock cycle. When the halt is released, a fresh cycle starts. Comparators and the gate driver are outside the block; their results arrive as synchronous single-bit flags.

Top module: `flyback_cycle_timer`

## Requirements
- R1: With zero-crossing seen early enough, each cycle lasts exactly the programmed period P = `period_i` + hop offset, measured from one rising gate edge to the next.
- R2: The hop offset starts at 0 and rises first. It changes by one every HOP_DWELL cycles and reverses direction at +HOP_SPAN and -HOP_SPAN. The offset in force at a turn-on sets that cycle's P.
- R3: A voltage or current request sampled high at on-tick k (k counted from 0 at turn-on, k >= MIN_ON_TICKS-1) ends the pulse, giving an on-length of k+1. The earliest request wins; both requests in the same tick give the same result.
- R4: A current request at on-ticks 0 to LEB_TICKS-1 is discarded and is not remembered.
- R5: A request accepted before on-tick MIN_ON_TICKS-1 is held, and the pulse ends with an on-length of exactly MIN_ON_TICKS.
- R6: The on-length never exceeds floor(P*DUTY_NUM/DUTY_DEN); without requests it equals that value.
- R7: A zero-crossing sampled at tick c of a cycle while the gate is low gives a cycle length of max(P, c+1+floor(P/GAP_DEN)).
- R8: A zero-crossing flag sampled while the gate is high is ignored.
- R9: Without an accepted zero-crossing, the cycle length is LIMIT_TICKS.
- R10: While `halt_i` is high, `gate_o` is low in the same clock cycle and stays low. The first clock edge with `halt_i` low starts a new full cycle.
- R11: `gate_o` is low during reset, and the first cycle starts at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | CW | Base period in clock ticks |
| vloop_rst_i | input | 1 | Voltage-loop pulse-termination request |
| iloop_rst_i | input | 1 | Current-loop pulse-termination request |
| zcd_i | input | 1 | Demagnetisation zero-crossing flag |
| halt_i | input | 1 | Forces gate low and restarts the cycle on release |
| gate_o | output | 1 | Gate enable |

## Verification
Both termination requests can rise in the same clock tick. The bench drives them together at one on-tick and expects an on-length one tick longer than that index. In another cycle, a current request placed inside the blanking window overlaps the minimum-on interval. There the bench expects the maximum-duty length, because the discarded request must not be held as pending. A scoreboard compares the measured on-length and cycle length of every cycle against values computed from the requirements.

// File: rtl/flyback_cycle_timer.sv
`timescale 1ns/1ps
module flyback_cycle_timer #(
  parameter int CW           = 10,
  parameter int LEB_TICKS    = 3,
  parameter int MIN_ON_TICKS = 6,
  parameter int DUTY_NUM     = 2,
  parameter int DUTY_DEN     = 3,
  parameter int GAP_DEN      = 10,
  parameter int LIMIT_TICKS  = 472,
  parameter int HOP_SPAN     = 3,
  parameter int HOP_DWELL    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] period_i,
  input  logic          vloop_rst_i,
  input  logic          iloop_rst_i,
  input  logic          zcd_i,
  input  logic          halt_i,
  output logic          gate_o
);
  localparam int DW = (HOP_DWELL > 1) ? $clog2(HOP_DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT_TICKS - 1);
  localparam logic [CW-1:0] MINL = CW'(MIN_ON_TICKS - 1);
  localparam logic [CW-1:0] LEBL = CW'(LEB_TICKS);
  localparam logic [DW-1:0] DWL  = DW'(HOP_DWELL - 1);
  localparam logic signed [CW:0] SPAN_P = (CW+1)'(HOP_SPAN);
  localparam logic signed [CW:0] SPAN_N = -SPAN_P;

  logic [CW-1:0] cnt, per_q, mo_q, tn_q, dz;
  logic gate_q, pend, zseen, restart, hop_up;
  logic [DW-1:0] dwell;
  logic signed [CW:0] hop_ofs;

  logic [CW:0]   per_sum;
  logic [CW+3:0] prod;
  logic [CW-1:0] per_next, mo_next, tn_next;
  assign per_sum  = {1'b0, period_i} + $unsigned(hop_ofs);
  assign per_next = per_sum[CW-1:0];
  assign prod     = {4'b0, per_next} * (CW+4)'(DUTY_NUM);
  assign mo_next  = CW'(prod / (CW+4)'(DUTY_DEN));
  assign tn_next  = per_next / CW'(GAP_DEN);

  logic req, off, boundary, forced, start;
  assign req      = vloop_rst_i | (iloop_rst_i & (cnt >= LEBL));
  assign off      = gate_q & ((((req | pend) & (cnt >= MINL))) | (cnt >= mo_q - CW'(1)));
  assign boundary = !gate_q & zseen & (cnt >= per_q - CW'(1)) & (dz >= tn_q - CW'(1));
  assign forced   = (cnt == LAST);
  assign start    = restart | boundary | forced;
  assign gate_o   = gate_q & ~halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0; gate_q <= 1'b0; pend <= 1'b0; zseen <= 1'b0; dz <= '0;
      restart <= 1'b1; per_q <= '0; mo_q <= '0; tn_q <= '0;
      hop_ofs <= '0; hop_up <= 1'b1; dwell <= '0;
    end else if (halt_i) begin
      cnt <= '0; gate_q <= 1'b0; pend <= 1'b0; zseen <= 1'b0; dz <= '0;
      restart <= 1'b1;
    end else if (start) begin
      cnt <= '0; gate_q <= 1'b1; pend <= 1'b0; zseen <= 1'b0; dz <= '0;
      restart <= 1'b0;
      per_q <= per_next; mo_q <= mo_next; tn_q <= tn_next;
      if (dwell == DWL) begin
        dwell <= '0;
        if (hop_up) begin
          if (hop_ofs == SPAN_P) begin hop_up <= 1'b0; hop_ofs <= hop_ofs - 1'b1; end
          else hop_ofs <= hop_ofs + 1'b1;
        end else begin
          if (hop_ofs == SPAN_N) begin hop_up <= 1'b1; hop_ofs <= hop_ofs + 1'b1; end
          else hop_ofs <= hop_ofs - 1'b1;
        end
      end else begin
        dwell <= dwell + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (off) gate_q <= 1'b0;
      pend <= gate_q & !off & (pend | req);
      if (!gate_q && zcd_i && !zseen) begin
        zseen <= 1'b1; dz <= '0;
      end else if (zseen && dz != '1) begin
        dz <= dz + 1'b1;
      end
    end
  end

  // on-time bounds
  p_min_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_q) && !$past(halt_i) |-> $past(cnt) >= MINL);
  p_max_duty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> cnt < mo_q);
  // cycle start rules
  p_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) && !$past(restart) |-> $past(cnt) >= $past(per_q) - CW'(1));
  p_zcd_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) && !$past(restart) && $past(cnt) != LAST |-> $past(zseen));
  p_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LAST);
  p_hop_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_ofs <= SPAN_P && hop_ofs >= SPAN_N);
  p_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !gate_q);
endmodule

// File: tb/flyback_cycle_timer_tb_top.sv
`timescale 1ns/1ps
module flyback_cycle_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10, LEB = 3, MINON = 6, DNUM = 2, DDEN = 3, GDEN = 10;
  localparam int LIMIT = 472, SPAN = 3, DWELL = 2, BASE = 100;

  logic clk = 0, rst_n = 0, vrst = 0, irst = 0, zcd = 0, halt = 0, gate;
  logic [CW-1:0] period = CW'(BASE);
  always #(CLK_PERIOD/2) clk = ~clk;

  flyback_cycle_timer #(.CW(CW), .LEB_TICKS(LEB), .MIN_ON_TICKS(MINON), .DUTY_NUM(DNUM),
    .DUTY_DEN(DDEN), .GAP_DEN(GDEN), .LIMIT_TICKS(LIMIT), .HOP_SPAN(SPAN), .HOP_DWELL(DWELL))
  dut_i (.clk_i(clk), .rst_ni(rst_n), .period_i(period), .vloop_rst_i(vrst),
    .iloop_rst_i(irst), .zcd_i(zcd), .halt_i(halt), .gate_o(gate));

  typedef struct { int on; int len; string ton; string tlen; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  int ofs = 0, dw = 0;
  bit up = 1, mon_en = 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int next_period();
    int p = BASE + ofs;
    if (dw == DWELL - 1) begin
      dw = 0;
      if (up) begin if (ofs == SPAN) begin up = 0; ofs--; end else ofs++; end
      else begin if (ofs == -SPAN) begin up = 1; ofs++; end else ofs--; end
    end else dw++;
    return p;
  endfunction

  // driver: called at the negedge where the gate has just risen (on-tick 0)
  task automatic run_cycle(int v, int i, int zc, string ton, string tlen);
    exp_t e;
    int p = next_period();
    int mo = (p * DNUM) / DDEN;
    int first = 1 << 20;
    int k = 0;
    bit was_low = 0;
    if (v >= 0) first = v;
    if (i >= LEB && i < first) first = i;
    e.on = (first == (1 << 20)) ? mo : ((first > MINON - 1 ? first : MINON - 1) + 1);
    if (e.on > mo) e.on = mo;
    if (zc >= e.on) begin
      e.len = zc + 1 + p / GDEN;
      if (e.len < p) e.len = p;
      if (e.len > LIMIT) e.len = LIMIT;
    end else e.len = LIMIT;
    e.ton = ton; e.tlen = tlen;
    q.push_back(e);
    forever begin
      vrst = (k == v); irst = (k == i); zcd = (k == zc);
      @(negedge clk);
      k++;
      if (gate == 0) was_low = 1;
      else if (was_low) break;
    end
    vrst = 0; irst = 0; zcd = 0;
  endtask

  // monitor / scoreboard
  bit have = 0, gp = 0;
  int hi = 0, tot = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      have = 0; gp = gate;
    end else begin
      if (gate && !gp) begin
        if (have) begin
          exp_t e;
          if (q.size() == 0) chk(0, "scoreboard empty", 0, 1);
          else begin
            e = q.pop_front();
            chk(hi == e.on, {e.ton, " on-length"}, hi, e.on);
            chk(tot == e.len, {e.tlen, " cycle length"}, tot, e.len);
          end
        end
        have = 1; hi = 1; tot = 1;
      end else if (have) begin
        tot++; hi += int'(gate);
      end
      gp = gate;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog all requirements act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(gate == 0, "R11 gate in reset", int'(gate), 0);
    rst_n = 1;
    @(negedge clk);
    chk(gate == 1, "R11 first turn-on", int'(gate), 1);
    run_cycle(30, -1, 50, "R3 voltage", "R1 R2");
    run_cycle(-1, 40, 60, "R3 current", "R1 R2");
    run_cycle(45, 20, 70, "R3 earliest", "R1 R2");
    run_cycle(20, 20, 70, "R3 same tick", "R1 R2");
    run_cycle(-1, 1, 80, "R4 R6 blanked", "R1 R2");
    run_cycle(-1, 4, 80, "R5 current held", "R1 R2");
    run_cycle(2, -1, 80, "R5 voltage held", "R1 R2");
    run_cycle(-1, -1, 85, "R6 max duty", "R1 R2");
    run_cycle(30, -1, 95, "R3", "R7 late zero-crossing");
    run_cycle(30, -1, 89, "R3", "R7 boundary");
    run_cycle(30, -1, -1, "R3", "R9 forced start");
    run_cycle(30, -1, 10, "R3", "R8 zero-crossing during on");
    // halt in the middle of an on-time
    void'(next_period());
    repeat (5) @(negedge clk);
    #1; mon_en = 0; halt = 1;
    #1; chk(gate == 0, "R10 immediate low", int'(gate), 0);
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      zcd = (n == 10);
      chk(gate == 0, "R10 held low", int'(gate), 0);
    end
    zcd = 0;
    @(negedge clk);
    #1; halt = 0; mon_en = 1;
    @(negedge clk);
    chk(gate == 1, "R10 restart", int'(gate), 1);
    run_cycle(25, -1, 60, "R10 R3 after restart", "R10 R1 after restart");
    run_cycle(-1, -1, 50, "R10 R6", "R10 R1");
    @(negedge clk);
    mon_en = 0;
    chk(q.size() == 0, "R1 scoreboard drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule